// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 20-bit virtual page number. A walk request carries the page number. The block forms the address of the first-level (directory) entry from a programmable directory base register. It reads that entry through a single-outstanding memory read port. It then forms the address of the second-level (table) entry from the table base held in the directory entry and reads that entry too. The walk ends with a one-cycle result: either the physical page number or a fault flag.

Both levels are 1024-entry tables of 4-byte entries, and bit 0 of each entry marks it present. The block remembers the most recent present directory entry together with its directory index. When a later walk uses the same directory index, the first read is skipped. Software clears this remembered entry by writing the directory base register or by pulsing a flush input.

Top module: `page_walker`

## Requirements
- R1: After synchronous reset, walk_req_ready is 1, mem_req_valid is 0 and res_valid is 0.
- R2: The directory read address equals the directory base plus 4 times the directory index, which is vpn[19:10].
- R3: The table read address equals {directory entry bits 31:12, 12'h000} plus 4 times the table index, which is vpn[9:0].
- R4: When both entries have bit 0 set, the result gives res_fault 0 and res_ppn equal to table entry bits 31:12.
- R5: A directory entry with bit 0 clear ends the walk after that single read, with res_fault 1 and res_ppn 0. Such an entry is never remembered.
- R6: A table entry with bit 0 clear ends the walk with res_fault 1 and res_ppn 0.
- R7: A walk whose directory index matches the remembered present entry issues only the table read.
- R8: Writing the directory base register (dir_base_we) forgets the remembered entry, and the next walk reads the directory again. The newly written base is used for that read.
- R9: A flush pulse forgets the remembered entry. A flush in the same cycle as a directory response leaves nothing remembered.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, the request stays valid and its address does not change.
- R11: Each accepted walk yields exactly one res_valid pulse of one cycle. walk_req_ready and mem_req_valid are never both 1, and walk_req_ready drops in the cycle after a walk is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_req_valid | input | 1 | Walk request present |
| walk_req_ready | output | 1 | Walker idle and able to accept a walk |
| walk_vpn | input | 20 | Virtual page number to translate |
| dir_base_we | input | 1 | Write strobe for the directory base register |
| dir_base_wdata | input | 32 | New directory base address |
| flush | input | 1 | Forget the remembered directory entry |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk hit a non-present entry |
| res_ppn | output | 20 | Physical page number (0 on fault) |

## Verification
The remembered-entry fill and its invalidation can occur in the same cycle: a flush arrives exactly as the directory response is taken. The memory model in the bench raises flush on the very cycle it returns a directory entry, while that walk is still completing normally. The outcome is judged by the next walk with the same directory index. That walk must issue two reads rather than one, and the bench checks both the count and each address against its own model of the tables.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_TBL,
    ST_WT_TBL,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFFS_W = 12
) (
  input  logic [ADDR_W-1:0]        dir_base,
  input  logic [ADDR_W-OFFS_W-1:0] tbl_base,
  input  logic [2*IDX_W-1:0]       vpn,
  output logic [ADDR_W-1:0]        dir_addr,
  output logic [ADDR_W-1:0]        tbl_addr
);
  localparam int SHIFT = $clog2(ADDR_W / 8);
  localparam int PAD   = ADDR_W - IDX_W - SHIFT;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;

  assign dir_idx = vpn[2*IDX_W-1:IDX_W];
  assign tbl_idx = vpn[IDX_W-1:0];

  assign dir_addr = dir_base + {{PAD{1'b0}}, dir_idx, {SHIFT{1'b0}}};
  assign tbl_addr = {tbl_base, {OFFS_W{1'b0}}} + {{PAD{1'b0}}, tbl_idx, {SHIFT{1'b0}}};
endmodule

// File: rtl/pw_dir_cache.sv
module pw_dir_cache #(
  parameter int IDX_W  = 10,
  parameter int BASE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv,
  input  logic              fill,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [BASE_W-1:0] fill_base,
  input  logic [IDX_W-1:0]  look_idx,
  output logic              hit,
  output logic [BASE_W-1:0] hit_base
);
  logic              vld_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst || inv) begin
      vld_q <= 1'b0;
    end else if (fill) begin
      vld_q <= 1'b1;
    end
    if (fill && !inv) begin
      idx_q  <= fill_idx;
      base_q <= fill_base;
    end
  end

  assign hit      = vld_q && (idx_q == look_idx);
  assign hit_base = base_q;
endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFFS_W = 12,
  localparam int VPN_W  = 2 * IDX_W,
  localparam int BASE_W = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              walk_req_valid,
  output logic              walk_req_ready,
  input  logic [VPN_W-1:0]  walk_vpn,
  input  logic              dir_base_we,
  input  logic [ADDR_W-1:0] dir_base_wdata,
  input  logic              flush,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic              res_fault,
  output logic [BASE_W-1:0] res_ppn
);
  walk_state_t       state_q;
  logic [ADDR_W-1:0] dir_base_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [BASE_W-1:0] tbase_q;
  logic [BASE_W-1:0] ppn_q;
  logic              fault_q;

  logic              inv;
  logic              fill;
  logic              hit;
  logic              hit_use;
  logic [BASE_W-1:0] hit_base;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;
  logic              present;
  logic              unused_rsp_bits;

  assign present         = mem_rsp_data[0];
  assign unused_rsp_bits = ^mem_rsp_data[OFFS_W-1:1];
  assign inv             = dir_base_we | flush;
  assign fill            = (state_q == ST_WT_DIR) && mem_rsp_valid && present;
  assign hit_use         = hit && !inv;

  pw_addr_gen #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFS_W(OFFS_W)
  ) u_addr (
    .dir_base (dir_base_q),
    .tbl_base (tbase_q),
    .vpn      (vpn_q),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr)
  );

  pw_dir_cache #(
    .IDX_W(IDX_W), .BASE_W(BASE_W)
  ) u_cache (
    .clk       (clk),
    .rst       (rst),
    .inv       (inv),
    .fill      (fill),
    .fill_idx  (vpn_q[VPN_W-1:IDX_W]),
    .fill_base (mem_rsp_data[ADDR_W-1:OFFS_W]),
    .look_idx  (walk_vpn[VPN_W-1:IDX_W]),
    .hit       (hit),
    .hit_base  (hit_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      dir_base_q <= '0;
      vpn_q      <= '0;
      tbase_q    <= '0;
      ppn_q      <= '0;
      fault_q    <= 1'b0;
    end else begin
      if (dir_base_we) dir_base_q <= dir_base_wdata;
      unique case (state_q)
        ST_IDLE: begin
          if (walk_req_valid) begin
            vpn_q   <= walk_vpn;
            ppn_q   <= '0;
            fault_q <= 1'b0;
            if (hit_use) begin
              tbase_q <= hit_base;
              state_q <= ST_RD_TBL;
            end else begin
              state_q <= ST_RD_DIR;
            end
          end
        end
        ST_RD_DIR: if (mem_req_ready) state_q <= ST_WT_DIR;
        ST_WT_DIR: begin
          if (mem_rsp_valid) begin
            if (!present) begin
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              tbase_q <= mem_rsp_data[ADDR_W-1:OFFS_W];
              state_q <= ST_RD_TBL;
            end
          end
        end
        ST_RD_TBL: if (mem_req_ready) state_q <= ST_WT_TBL;
        ST_WT_TBL: begin
          if (mem_rsp_valid) begin
            if (!present) fault_q <= 1'b1;
            else          ppn_q   <= mem_rsp_data[ADDR_W-1:OFFS_W];
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign walk_req_ready = (state_q == ST_IDLE);
  assign mem_req_valid  = (state_q == ST_RD_DIR) || (state_q == ST_RD_TBL);
  assign mem_req_addr   = (state_q == ST_RD_TBL) ? tbl_addr : dir_addr;
  assign res_valid      = (state_q == ST_DONE);
  assign res_fault      = fault_q;
  assign res_ppn        = ppn_q;
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int PPN_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              walk_req_valid,
  input logic              walk_req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              res_valid,
  input logic              res_fault,
  input logic [PPN_W-1:0]  res_ppn
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (walk_req_ready && !mem_req_valid && !res_valid));

  assert_fault_zero_ppn_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_ppn == '0));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_res_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && walk_req_ready) |=> !walk_req_ready);

  assert_idle_no_read_R11: assert property (@(posedge clk) disable iff (rst)
    walk_req_ready |-> !mem_req_valid);
endmodule

bind page_walker page_walker_chk #(.ADDR_W(ADDR_W), .PPN_W(BASE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .res_valid      (res_valid),
  .res_fault      (res_fault),
  .res_ppn        (res_ppn)
);

// File: tb/page_walker_tb.sv
module page_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        walk_req_valid = 1'b0;
  logic        walk_req_ready;
  logic [19:0] walk_vpn = '0;
  logic        dir_base_we = 1'b0;
  logic [31:0] dir_base_wdata = '0;
  logic        flush_drv = 1'b0;
  logic        flush_mem = 1'b0;
  logic        flush;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_fault;
  logic [19:0] res_ppn;

  assign flush = flush_drv | flush_mem;

  always #10 clk = ~clk;

  page_walker u_dut (
    .clk(clk), .rst(rst),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready), .walk_vpn(walk_vpn),
    .dir_base_we(dir_base_we), .dir_base_wdata(dir_base_wdata), .flush(flush),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_ppn(res_ppn)
  );

  typedef struct {
    logic [19:0] ppn;
    logic        fault;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  string       atag_q[$];
  logic [31:0] mem_tbl [logic [31:0]];

  int n_chk = 0, n_bad = 0, n_res = 0, n_walk = 0;
  int rd_cnt = 0;
  bit arm_flush = 1'b0;
  bit finished = 1'b0;

  logic [31:0] m_base = '0;
  bit          m_vld = 1'b0;
  logic [9:0]  m_idx = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_tbl.exists(a) ? mem_tbl[a] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Driver: predicts the result from the bench's own table model and issues one walk.
  task automatic walk(input logic [9:0] di, input logic [9:0] ti, input bit flush_rsp, input string tag);
    exp_t e;
    logic [31:0] pde, pte, tbl_a;
    bit h;
    h     = m_vld && (m_idx == di);
    pde   = rd(m_base + {20'h0, di, 2'b00});
    e.tag = tag;
    if (!h) begin
      addr_q.push_back(m_base + {20'h0, di, 2'b00});
      atag_q.push_back({tag, " dir addr R2"});
    end
    if (!pde[0]) begin
      e.fault = 1'b1; e.ppn = '0; e.reads = 1;
    end else begin
      tbl_a = {pde[31:12], 12'h000} + {20'h0, ti, 2'b00};
      addr_q.push_back(tbl_a);
      atag_q.push_back({tag, " tbl addr R3"});
      pte     = rd(tbl_a);
      e.reads = h ? 1 : 2;
      e.fault = !pte[0];
      e.ppn   = pte[0] ? pte[31:12] : 20'h0;
      if (!h) begin
        if (flush_rsp) m_vld = 1'b0;
        else begin m_vld = 1'b1; m_idx = di; end
      end
    end
    exp_q.push_back(e);
    while (!walk_req_ready) @(negedge clk);
    rd_cnt = 0;
    arm_flush = flush_rsp;
    walk_vpn = {di, ti};
    walk_req_valid = 1'b1;
    n_walk++;
    @(negedge clk);
    walk_req_valid = 1'b0;
    while (!walk_req_ready) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk); flush_drv = 1'b1;
    @(negedge clk); flush_drv = 1'b0;
    m_vld = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); dir_base_we = 1'b1; dir_base_wdata = b;
    @(negedge clk); dir_base_we = 1'b0;
    m_base = b; m_vld = 1'b0;
  endtask

  // Memory model: variable ready and latency; checks each request address.
  initial begin
    bit pend = 1'b0, pend_fl = 1'b0;
    int dly = 0, rcnt = 0;
    logic [31:0] pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      flush_mem     = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(pa);
          if (pend_fl) flush_mem = 1'b1;
          pend = 1'b0; pend_fl = 1'b0;
        end else dly--;
      end
      rcnt++;
      mem_req_ready = (rcnt % 3) != 0;
      if (mem_req_valid && mem_req_ready && !pend) begin
        pa = mem_req_addr;
        pend = 1'b1;
        dly = rcnt % 3;
        pend_fl = arm_flush && (rd_cnt == 0);
        if (pend_fl) arm_flush = 1'b0;
        rd_cnt++;
        if (addr_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R7: unexpected read at %h, expected none", mem_req_addr);
        end else begin
          check(atag_q.pop_front(), mem_req_addr, addr_q.pop_front());
        end
      end
    end
  end

  // Monitor: pops expected results as the walker produces them.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (res_valid) begin
        n_res++;
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R11: extra result ppn %h, expected none", res_ppn);
        end else begin
          e = exp_q.pop_front();
          check({e.tag, " ppn R4/R6"}, {12'h0, res_ppn}, {12'h0, e.ppn});
          check({e.tag, " fault R5/R6"}, {31'h0, res_fault}, {31'h0, e.fault});
          check({e.tag, " read count R7"}, rd_cnt, e.reads);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mem_tbl[32'h0001_0004] = 32'h0020_0001;   // dir idx 1 -> table at 0x200000
    mem_tbl[32'h0001_000C] = 32'h0030_0001;   // dir idx 3 -> table at 0x300000
    mem_tbl[32'h0020_0014] = 32'hABCD_E001;   // idx 5
    mem_tbl[32'h0020_0FFC] = 32'h1234_5001;   // idx 1023
    mem_tbl[32'h0020_0018] = 32'h5555_5000;   // idx 6, not present
    mem_tbl[32'h0030_0000] = 32'h0007_7001;
    mem_tbl[32'h0004_0004] = 32'h0030_0001;   // second directory, idx 1

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", {31'h0, walk_req_ready}, 32'h1);
    check("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    check("R1 res_valid", {31'h0, res_valid}, 32'h0);

    set_base(32'h0001_0000);
    walk(10'd1, 10'd5, 1'b0, "R4 miss present");
    walk(10'd1, 10'd1023, 1'b0, "R7 hit top index");
    walk(10'd1, 10'd6, 1'b0, "R6 hit absent pte");
    walk(10'd2, 10'd0, 1'b0, "R5 absent pde");
    walk(10'd1, 10'd5, 1'b0, "R7 hit kept after R5");
    do_flush();
    walk(10'd1, 10'd5, 1'b0, "R9 after flush");
    set_base(32'h0001_0000);
    walk(10'd1, 10'd5, 1'b0, "R8 after same base write");
    walk(10'd3, 10'd0, 1'b1, "R9 flush with dir rsp");
    walk(10'd3, 10'd0, 1'b0, "R9 no fill after collision");
    walk(10'd3, 10'd0, 1'b0, "R7 hit after refill");
    set_base(32'h0004_0000);
    walk(10'd1, 10'd0, 1'b0, "R8 new base used");
    walk(10'd1023, 10'd1023, 1'b0, "R5 top dir index absent");

    repeat (5) @(negedge clk);
    check("R11 results per walk", n_res, n_walk);
    check("R11 queue drained", exp_q.size(), 0);
    check("R7 no pending reads", addr_q.size(), 0);
    finish_run();
  end
endmodule